// File: doc/BRIEF.md
# Error-Report Cache with Interrupt Handshake

The block collects error-message words from a streaming source and keeps each distinct value in a small on-chip cache. A word that matches any entry already held in the cache is dropped. This applies to entries that have already been serviced as well as to entries still waiting. A word that arrives with its error strobe set is ignored.

A host processor sees one cache entry at a time, the oldest one that has not been serviced. It reads that entry through a small register read port. While an unserviced entry exists, the block holds an interrupt line high. The host writes the acknowledge offset once it has finished with the current entry. The block then moves on to the next entry and raises the interrupt again after a one-cycle gap.

When the cache is full, new distinct words are discarded and a sticky overflow flag is set. The flag stays set until the host clears it.

Top module: `errmsg_cache`

## Requirements
- R1: After a synchronous active-low reset, irq and overflow are 0 and reads at offsets 0, 1 and 2 return 0.
- R2: A word accepted on a clock edge (msg_valid=1, msg_err=0, not a duplicate) raises irq on the following edge. The current entry then reads as bits 31:0 at offset 0, bits 63:32 at offset 1 and bits 66:64 at offset 2, with bits 31:3 of offset 2 equal to zero. Reads at offsets 3 and above return 0.
- R3: A word equal to any entry held in the cache, whether serviced or not, is discarded. It does not raise irq and does not create an entry.
- R4: A word presented with msg_err=1 is discarded. The same value sent later without msg_err is accepted as new.
- R5: A host write to offset 3 acknowledges the current entry. irq is 0 in the cycle after the acknowledge. On the next edge irq returns to 1 if an unserviced entry remains, and that entry is now the one presented.
- R6: An acknowledge while no unserviced entry exists has no effect. The next word accepted afterwards is the one presented.
- R7: When the cache holds DEPTH entries, a new distinct word is discarded and overflow becomes 1 on that edge. A duplicate word received while the cache is full does not set overflow.
- R8: overflow stays 1 until a host write to offset 4 clears it. If an overflow event and a clear happen on the same edge, the flag stays 1.
- R9: Entries are presented in the order they were accepted. When every entry has been serviced, irq is 0 and reads at offsets 0 to 2 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_data | input | 67 | Error-message word |
| msg_valid | input | 1 | msg_data is valid this cycle |
| msg_err | input | 1 | Discard the word presented this cycle |
| host_addr | input | 3 | Register offset for reads and writes |
| host_wr | input | 1 | Host write strobe; offset 3 acknowledges, offset 4 clears overflow |
| host_rdata | output | 32 | Read data for the current entry at host_addr |
| irq | output | 1 | Unserviced entry present |
| overflow | output | 1 | Sticky: a distinct word was dropped because the cache was full |

## Verification
The assertions assume that the host acknowledges only through single-cycle writes to offset 3. They also assume that message words are meaningful only while msg_valid is high, so msg_err matters only alongside msg_valid.

The bench drives every strobe for exactly one cycle at the falling edge and samples at the next falling edge. It therefore never depends on how two writes to the same offset in consecutive cycles would combine. The fill count and read pointer that the checker observes can therefore only change through accepted words and acknowledges. This is what lets the checker hold them to the cache depth and to each other.

// File: rtl/emc_pkg.sv
// Shared definitions for the error-report cache: host register offsets
// and the host word width. Assumes messages fit in MAX_WORDS host words.
package emc_pkg;
    localparam int HOST_W    = 32;
    localparam int MAX_WORDS = 3;

    typedef enum logic [2:0] {
        OFF_WORD0 = 3'd0,
        OFF_WORD1 = 3'd1,
        OFF_WORD2 = 3'd2,
        OFF_ACK   = 3'd3,
        OFF_OVCLR = 3'd4
    } emc_off_e;
endpackage

// File: rtl/emc_store.sv
// Cache storage with a one-cycle duplicate check against every filled slot.
// Slots are filled in arrival order and are never freed until reset.
// Assumes DEPTH >= 2.
module emc_store #(
    parameter  int DEPTH = 8,
    parameter  int MSG_W = 67,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MSG_W-1:0] in_data,
    input  logic             in_valid,
    input  logic             in_err,
    input  logic [CNT_W-1:0] rd_idx,
    output logic [MSG_W-1:0] rd_entry,
    output logic [CNT_W-1:0] fill_cnt,
    output logic             ovf_evt
);
    logic [MSG_W-1:0] slot_q [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [DEPTH-1:0] hit;
    logic             dup;
    logic             full;
    logic             take;

    // One comparator per slot; only slots below the fill count can match.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        localparam logic [CNT_W-1:0] SLOT_NUM = CNT_W'(g);
        assign hit[g] = (SLOT_NUM < cnt_q) && (slot_q[g] == in_data);
    end

    assign dup     = |hit;
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign take    = in_valid && !in_err && !dup;
    assign ovf_evt = take && full;

    // Write a new distinct word into the next free slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (take && !full) begin
            slot_q[cnt_q[IDX_W-1:0]] <= in_data;
            cnt_q                    <= cnt_q + 1'b1;
        end
    end

    // Present the slot selected by the read index, zero past the end.
    always_comb begin
        if (rd_idx < CNT_W'(DEPTH)) rd_entry = slot_q[rd_idx[IDX_W-1:0]];
        else                        rd_entry = '0;
    end

    assign fill_cnt = cnt_q;
endmodule

// File: rtl/emc_service.sv
// Service sequencer: read pointer, interrupt with a one-cycle gap after
// each acknowledge, and sticky overflow flag. Assumes fill_cnt never decreases
// except through reset.
module emc_service #(
    parameter  int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] fill_cnt,
    input  logic             ack_req,
    input  logic             ovf_evt,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] rd_ptr,
    output logic             pending,
    output logic             irq,
    output logic             overflow
);
    logic [CNT_W-1:0] ptr_q;
    logic             irq_q;
    logic             ovf_q;

    assign pending = (ptr_q < fill_cnt);

    // Advance to the next entry on an acknowledge of a real entry.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ptr_q <= '0;
        else if (ack_req && pending) ptr_q <= ptr_q + 1'b1;
    end

    // Interrupt: forced low on an acknowledge, otherwise follows pending.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_q <= 1'b0;
        else if (ack_req) irq_q <= 1'b0;
        else              irq_q <= pending;
    end

    // Sticky overflow; a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_q <= 1'b0;
        else if (ovf_evt) ovf_q <= 1'b1;
        else if (ovf_clr) ovf_q <= 1'b0;
    end

    assign rd_ptr   = ptr_q;
    assign irq      = irq_q;
    assign overflow = ovf_q;
endmodule

// File: rtl/emc_hostif.sv
// Host register port: splits the current entry into 32-bit words, decodes
// the acknowledge and overflow-clear writes. Assumes MSG_W <= 96.
module emc_hostif
    import emc_pkg::*;
#(
    parameter int MSG_W = 67
) (
    input  logic              [2:0] host_addr,
    input  logic                    host_wr,
    input  logic        [MSG_W-1:0] entry,
    input  logic                    pending,
    output logic       [HOST_W-1:0] rdata,
    output logic                    ack_req,
    output logic                    ovf_clr
);
    localparam int PAD_W = MAX_WORDS * HOST_W;

    logic [PAD_W-1:0]  padded;
    logic [HOST_W-1:0] words [MAX_WORDS];

    assign padded = PAD_W'(entry);

    // Slice the zero-extended entry into host-sized words.
    for (genvar w = 0; w < MAX_WORDS; w++) begin : g_word
        assign words[w] = padded[w*HOST_W +: HOST_W];
    end

    // Read mux: current entry words at offsets 0..2, zero elsewhere or when idle.
    always_comb begin
        rdata = '0;
        if (pending && (host_addr < 3'(MAX_WORDS))) rdata = words[host_addr[1:0]];
    end

    // Write decode for the two command offsets.
    assign ack_req = host_wr && (host_addr == OFF_ACK);
    assign ovf_clr = host_wr && (host_addr == OFF_OVCLR);
endmodule

// File: rtl/errmsg_cache.sv
// Error-report cache top: stores distinct error-message words, presents them
// in arrival order to a host and raises an interrupt per unserviced entry.
// Assumes a single clock and synchronous active-low reset.
module errmsg_cache #(
    parameter int DEPTH = 8,
    parameter int MSG_W = 67
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MSG_W-1:0] msg_data,
    input  logic             msg_valid,
    input  logic             msg_err,
    input  logic [2:0]       host_addr,
    input  logic             host_wr,
    output logic [31:0]      host_rdata,
    output logic             irq,
    output logic             overflow
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] fill_cnt;
    logic [CNT_W-1:0] rd_ptr;
    logic [MSG_W-1:0] cur_entry;
    logic             ovf_evt;
    logic             pending;
    logic             ack_req;
    logic             ovf_clr;

    emc_store #(.DEPTH(DEPTH), .MSG_W(MSG_W)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (msg_data),
        .in_valid (msg_valid),
        .in_err   (msg_err),
        .rd_idx   (rd_ptr),
        .rd_entry (cur_entry),
        .fill_cnt (fill_cnt),
        .ovf_evt  (ovf_evt)
    );

    emc_service #(.DEPTH(DEPTH)) service_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill_cnt (fill_cnt),
        .ack_req  (ack_req),
        .ovf_evt  (ovf_evt),
        .ovf_clr  (ovf_clr),
        .rd_ptr   (rd_ptr),
        .pending  (pending),
        .irq      (irq),
        .overflow (overflow)
    );

    emc_hostif #(.MSG_W(MSG_W)) hostif_i (
        .host_addr (host_addr),
        .host_wr   (host_wr),
        .entry     (cur_entry),
        .pending   (pending),
        .rdata     (host_rdata),
        .ack_req   (ack_req),
        .ovf_clr   (ovf_clr)
    );
endmodule

// File: rtl/emc_chk.sv
// Property checker for the error-report cache, bound to the top module.
// Observes ports plus the fill count and read pointer between submodules.
module emc_chk
    import emc_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             msg_valid,
    input logic             msg_err,
    input logic [2:0]       host_addr,
    input logic             host_wr,
    input logic             irq,
    input logic             overflow,
    input logic [CNT_W-1:0] fill_cnt,
    input logic [CNT_W-1:0] rd_ptr
);
    // R2
    irq_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rd_ptr < fill_cnt));

    // R4
    err_word_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_err) |=> $stable(fill_cnt));

    // R5
    ack_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == OFF_ACK) |=> !irq);

    // R6
    idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == OFF_ACK && rd_ptr == fill_cnt) |=> $stable(rd_ptr));

    // R7
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= CNT_W'(DEPTH));

    // R7
    ovf_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> (fill_cnt == CNT_W'(DEPTH)));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !(host_wr && host_addr == OFF_OVCLR)) |=> overflow);
endmodule

bind errmsg_cache emc_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .msg_valid (msg_valid),
    .msg_err   (msg_err),
    .host_addr (host_addr),
    .host_wr   (host_wr),
    .irq       (irq),
    .overflow  (overflow),
    .fill_cnt  (fill_cnt),
    .rd_ptr    (rd_ptr)
);

// File: tb/errmsg_cache_tb_top.sv
// Directed bench for the error-report cache; one task per scenario.
module errmsg_cache_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int MSG_W      = 67;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [MSG_W-1:0] msg_data = '0;
    logic             msg_valid = 1'b0;
    logic             msg_err = 1'b0;
    logic [2:0]       host_addr = 3'd0;
    logic             host_wr = 1'b0;
    logic [31:0]      host_rdata;
    logic             irq;
    logic             overflow;

    int checks   = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    errmsg_cache #(.DEPTH(DEPTH), .MSG_W(MSG_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .msg_data   (msg_data),
        .msg_valid  (msg_valid),
        .msg_err    (msg_err),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_rdata (host_rdata),
        .irq        (irq),
        .overflow   (overflow)
    );

    function automatic logic [MSG_W-1:0] mk(input int i);
        return {3'(i) ^ 3'b101, 32'hA5A5_0000 + 32'(i), 32'h1000_0000 + 32'(i * 7)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; msg_valid = 1'b0; msg_err = 1'b0; host_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(input logic [MSG_W-1:0] w, input logic err);
        msg_data = w; msg_err = err; msg_valid = 1'b1;
        @(negedge clk);
        msg_valid = 1'b0; msg_err = 1'b0;
    endtask

    task automatic hwrite(input logic [2:0] a);
        host_addr = a; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic check_entry(input string req, input logic [MSG_W-1:0] w);
        logic [31:0] d;
        rd(3'd0, d); check(req, d, w[31:0]);
        rd(3'd1, d); check(req, d, w[63:32]);
        rd(3'd2, d); check(req, d, {29'd0, w[66:64]});
    endtask

    task automatic check_idle_reads(input string req);
        logic [31:0] d;
        for (int a = 0; a < 3; a++) begin
            rd(3'(a), d); check(req, d, 32'd0);
        end
    endtask

    // R1: reset state
    task automatic t_reset();
        do_reset();
        check("R1 irq", 32'(irq), 32'd0);
        check("R1 overflow", 32'(overflow), 32'd0);
        check_idle_reads("R1 reads");
    endtask

    // R2, R3, R5, R9: store, present, dedup, acknowledge in order
    task automatic t_basic();
        logic [31:0] d;
        do_reset();
        send(mk(1), 1'b0);
        check("R2 irq before second edge", 32'(irq), 32'd0);
        @(negedge clk);
        check("R2 irq raised", 32'(irq), 32'd1);
        check_entry("R2 entry words", mk(1));
        rd(3'd5, d); check("R2 unused offset", d, 32'd0);
        send(mk(1), 1'b0);      // duplicate of a pending entry
        send(mk(2), 1'b0);
        send(mk(2), 1'b0);      // duplicate again
        @(negedge clk);
        hwrite(3'd3);
        check("R5 irq gap", 32'(irq), 32'd0);
        @(negedge clk);
        check("R5 irq re-armed", 32'(irq), 32'd1);
        check_entry("R9 second entry", mk(2));
        hwrite(3'd3);
        @(negedge clk);
        check("R3 no entry from duplicates", 32'(irq), 32'd0);
        check_idle_reads("R9 drained reads");
        send(mk(1), 1'b0);      // duplicate of a serviced entry
        @(negedge clk);
        check("R3 serviced duplicate dropped", 32'(irq), 32'd0);
    endtask

    // R4: error strobe discards the word
    task automatic t_err();
        do_reset();
        send(mk(3), 1'b1);
        @(negedge clk);
        check("R4 irq after err word", 32'(irq), 32'd0);
        check_idle_reads("R4 reads after err word");
        send(mk(3), 1'b0);
        @(negedge clk);
        check("R4 same word accepted later", 32'(irq), 32'd1);
        check_entry("R4 entry", mk(3));
    endtask

    // R6: acknowledge with nothing pending
    task automatic t_idle_ack();
        do_reset();
        hwrite(3'd3);
        hwrite(3'd3);
        send(mk(4), 1'b0);
        @(negedge clk);
        check("R6 irq after idle acks", 32'(irq), 32'd1);
        check_entry("R6 entry presented", mk(4));
    endtask

    // R7, R8, R9: full cache, sticky overflow, drain in order
    task automatic t_full();
        do_reset();
        for (int i = 0; i < DEPTH; i++) send(mk(10 + i), 1'b0);
        check("R7 no overflow at full", 32'(overflow), 32'd0);
        send(mk(50), 1'b0);
        check("R7 overflow on drop", 32'(overflow), 32'd1);
        hwrite(3'd4);
        check("R8 clear", 32'(overflow), 32'd0);
        send(mk(12), 1'b0);
        check("R7 duplicate while full", 32'(overflow), 32'd0);
        send(mk(51), 1'b0);
        repeat (3) @(negedge clk);
        check("R8 sticky", 32'(overflow), 32'd1);
        hwrite(3'd4);
        msg_data = mk(52); msg_valid = 1'b1;
        host_addr = 3'd4; host_wr = 1'b1;
        @(negedge clk);
        msg_valid = 1'b0; host_wr = 1'b0;
        check("R8 set wins over clear", 32'(overflow), 32'd1);
        for (int i = 0; i < DEPTH; i++) begin
            check("R5 irq before ack", 32'(irq), 32'd1);
            check_entry("R9 arrival order", mk(10 + i));
            hwrite(3'd3);
            check("R5 irq low after ack", 32'(irq), 32'd0);
            @(negedge clk);
        end
        check("R9 irq after drain", 32'(irq), 32'd0);
        check_idle_reads("R9 reads after drain");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_err();
        t_idle_ack();
        t_full();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule